// File: doc/BRIEF.md
# Serial Audio Output Port

This block turns a stream of stereo PCM sample pairs into a three-wire serial audio signal: a bit clock, a left/right frame clock and one data line. Three framings are available: left-justified, I²S and right-justified. Four sample resolutions can be selected, and only the most significant bits of each 24-bit input word are sent. The port can be a clock slave, where it follows a bit clock and frame clock from elsewhere. It can also be a clock master, where it divides its master clock down to make both clocks itself.

Samples arrive as a left/right word pair with a valid/ready handshake. The block holds one pending pair and moves it into the active pair at the start of each frame. If no new pair has arrived by then, the previous pair is sent again. The configuration is written through a small set of input fields with a write strobe. A write takes effect only while the power-down input is high. While power-down is high, the port is idle.

All logic runs on the master clock. In slave mode the external clocks are oversampled by the master clock. Each data bit changes a few master-clock cycles after the bit-clock falling edge, so one half bit-clock period must be at least four master-clock cycles.

Top module: `serial_audio_out`

## Requirements
- R1: The resolution field `cfg_res` selects how many MSBs of each 24-bit word are sent: 0 = 24, 1 = 20, 2 = 18, 3 = 16. The input bits below that width are never sent, and the slots they would have used are driven as zero.
- R2: Left-justified (`cfg_fmt` = 0): the MSB is in slot 0 of each half-frame. Frame clock high marks the left channel.
- R3: I²S (`cfg_fmt` = 1): slot 0 is zero and the MSB is in slot 1. Frame clock low marks the left channel. A 24-slot half-frame can therefore carry only 23 bits.
- R4: Right-justified (`cfg_fmt` = 2): the LSB of the selected resolution is in the last slot of the half-frame, and the leading slots are zero. The frame-clock polarity is the same as left-justified. A write that selects right-justified together with slave mode is discarded as a whole.
- R5: Master mode (`cfg_master` = 1): `sclk_oe` and `lrck_oe` are high while running. The master-clock-per-frame ratio code `cfg_ratio` maps 4→256, 5→384, 6→512, 7→768 and 8→1024. A half-frame has 32 slots (ratios 256/512/1024) or 24 slots (ratios 384/768), doubled when `cfg_bclk_sel` = 1. The bit-clock period is ratio / (2 × half-frame slots) master clocks. Slot 0 of the left channel starts when power-down is released.
- R6: Slave mode (`cfg_master` = 0): both output enables stay low. Every falling edge of `sclk_in` advances the slot. A change of `lrck_in` at a falling edge starts slot 0 of the channel that the new level marks.
- R7: A configuration write is applied only if `pdn` is high. A write is also discarded when the ratio code is outside 4..8 or the format code is 3.
- R8: `smp_ready` is high while the single pending slot is empty. An accepted pair becomes active at the next left-channel start, or at once during power-down. Without a new pair, the active pair is sent again.
- R9: In slave mode, once the first frame-clock edge has been seen, a frame-clock edge that ends a half-frame whose slot count differs from the configured count raises `frame_err` for one cycle.
- R10: While `pdn` is high, `sdout` is zero and both output enables are low. After reset the configuration is slave, left-justified, 24-bit, ratio code 4, and `smp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Power-down: idles the port and opens configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_master | input | 1 | 1 = clock master, 0 = clock slave |
| cfg_bclk_sel | input | 1 | Selects the doubled bit-clock rate |
| cfg_res | input | 2 | Resolution code |
| cfg_fmt | input | 2 | Framing code |
| cfg_ratio | input | 4 | Master-clock per frame ratio code |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Pending slot empty |
| smp_left | input | 24 | Left sample, MSB first |
| smp_right | input | 24 | Right sample, MSB first |
| sclk_in | input | 1 | External bit clock (slave) |
| lrck_in | input | 1 | External frame clock (slave) |
| sclk_out | output | 1 | Generated bit clock (master) |
| sclk_oe | output | 1 | Drive enable for the bit-clock pin |
| lrck_out | output | 1 | Generated frame clock (master) |
| lrck_oe | output | 1 | Drive enable for the frame-clock pin |
| sdout | output | 1 | Serial data, changes after bit-clock falling edges |
| frame_err | output | 1 | One-cycle slave frame length error |

## Verification
The bench sweeps every framing, resolution, ratio code and bit-clock choice in master mode. At each bit-clock rising edge it compares the data line and the frame clock against values computed from slot arithmetic. A wrong slot offset would shift every word by one or more bits. A wrong divider shows up in the measured bit-clock period. Stale-sample and handshake faults are exposed by sending a second pair in the middle of a frame and then letting a later frame repeat it. Separate runs try configuration writes that must be dropped: a write while running, an illegal ratio code, the reserved format, and right-justified in slave mode. Slave runs drive deliberately short half-frames, so a design that misses or invents frame errors is caught.

// File: rtl/sao_pkg.sv
package sao_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SLOT_W   = 7;
  localparam int DIV_W    = 5;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  typedef struct packed {
    logic       master;
    logic       bclk_sel;
    logic [1:0] res;
    fmt_e       fmt;
    logic [3:0] ratio;
  } cfg_t;

  localparam cfg_t CFG_RST = '{master: 1'b0, bclk_sel: 1'b0, res: 2'b00,
                               fmt: FMT_LJ, ratio: 4'd4};

  function automatic logic ratio_ok(input logic [3:0] code);
    return (code >= 4'd4) && (code <= 4'd8);
  endfunction

  // slots per half-frame: 24-based for the 1.5x ratios (odd codes)
  function automatic logic [SLOT_W-1:0] half_len(input logic [3:0] code, input logic bsel);
    logic [SLOT_W-1:0] base;
    base = code[0] ? SLOT_W'(24) : SLOT_W'(32);
    return bsel ? (base << 1) : base;
  endfunction

  // master clocks per bit clock, always a power of two
  function automatic logic [DIV_W-1:0] sclk_div(input logic [3:0] code, input logic bsel);
    logic [3:0]       step;
    logic [DIV_W-1:0] d;
    step = (code - 4'd3) >> 1;
    d    = DIV_W'(4) << step;
    return bsel ? (d >> 1) : d;
  endfunction

  function automatic logic [4:0] res_bits(input logic [1:0] r);
    case (r)
      2'd0:    return 5'd24;
      2'd1:    return 5'd20;
      2'd2:    return 5'd18;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/sao_cfg.sv
module sao_cfg
  import sao_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pdn,
  input  logic wr_en,
  input  cfg_t wr_cfg,
  output cfg_t cfg_q
);
  cfg_t cfg_d;
  logic legal;

  always_comb begin
    legal = ratio_ok(wr_cfg.ratio) && (wr_cfg.fmt != FMT_RSV) &&
            !((wr_cfg.fmt == FMT_RJ) && !wr_cfg.master);
    cfg_d = cfg_q;
    if (wr_en && pdn && legal) cfg_d = wr_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_d;
  end

  // R4
  rj_master_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.fmt == FMT_RJ) |-> cfg_q.master);

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn |=> $stable(cfg_q));
endmodule

// File: rtl/sao_timing.sv
module sao_timing
  import sao_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  cfg_t              cfg,
  input  logic              sclk_in,
  input  logic              lrck_in,
  output logic              chan,
  output logic [SLOT_W-1:0] slot,
  output logic              frame_start,
  output logic              sclk_out,
  output logic              lrck_out,
  output logic              err_frame
);
  logic [DIV_W-1:0]  div, cnt_q, cnt_d;
  logic [SLOT_W-1:0] half, slot_q, slot_d;
  logic [2:0]        sclk_s_q;
  logic [1:0]        lrck_s_q;
  logic chan_q, chan_d, lr_prev_q, lr_prev_d, locked_q, locked_d, err_q, err_d;
  logic m_tick, s_fall, s_edge, lr_cur, left_lvl;

  always_comb begin
    div      = sclk_div(cfg.ratio, cfg.bclk_sel);
    half     = half_len(cfg.ratio, cfg.bclk_sel);
    m_tick   = run && cfg.master && (cnt_q == div - DIV_W'(1));
    s_fall   = run && !cfg.master && sclk_s_q[2] && !sclk_s_q[1];
    lr_cur   = lrck_s_q[1];
    left_lvl = (cfg.fmt != FMT_I2S);
    s_edge   = s_fall && (lr_cur != lr_prev_q);

    cnt_d       = cnt_q;
    chan_d      = chan_q;
    slot_d      = slot_q;
    lr_prev_d   = lr_prev_q;
    locked_d    = locked_q;
    err_d       = 1'b0;
    frame_start = 1'b0;

    if (!run) begin
      cnt_d     = '0;
      chan_d    = 1'b0;
      slot_d    = '0;
      lr_prev_d = lr_cur;
      locked_d  = 1'b0;
    end else if (cfg.master) begin
      cnt_d = m_tick ? '0 : cnt_q + DIV_W'(1);
      if (m_tick) begin
        if (slot_q == half - SLOT_W'(1)) begin
          slot_d      = '0;
          chan_d      = ~chan_q;
          frame_start = chan_q;
        end else begin
          slot_d = slot_q + SLOT_W'(1);
        end
      end
    end else if (s_fall) begin
      lr_prev_d = lr_cur;
      if (s_edge) begin
        chan_d      = (lr_cur != left_lvl);
        slot_d      = '0;
        frame_start = (lr_cur == left_lvl);
        locked_d    = 1'b1;
        err_d       = locked_q && (slot_q != half - SLOT_W'(1));
      end else if (slot_q != '1) begin
        slot_d = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      chan_q    <= 1'b0;
      slot_q    <= '0;
      lr_prev_q <= 1'b0;
      locked_q  <= 1'b0;
      err_q     <= 1'b0;
      sclk_s_q  <= '0;
      lrck_s_q  <= '0;
    end else begin
      cnt_q     <= cnt_d;
      chan_q    <= chan_d;
      slot_q    <= slot_d;
      lr_prev_q <= lr_prev_d;
      locked_q  <= locked_d;
      err_q     <= err_d;
      sclk_s_q  <= {sclk_s_q[1:0], sclk_in};
      lrck_s_q  <= {lrck_s_q[0], lrck_in};
    end
  end

  assign chan      = chan_q;
  assign slot      = slot_q;
  assign err_frame = err_q;
  assign sclk_out  = run && cfg.master && (cnt_q >= (div >> 1));
  assign lrck_out  = run && cfg.master && ((cfg.fmt == FMT_I2S) ? chan_q : ~chan_q);

  // R5
  sclk_low_after_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tick |=> !sclk_out);

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cfg.master) |-> (slot_q < half));

  // R9
  err_slave_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |-> !cfg.master);
endmodule

// File: rtl/sao_shift.sv
module sao_shift
  import sao_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  fmt_e                fmt,
  input  logic [1:0]          res,
  input  logic [SLOT_W-1:0]   half,
  input  logic                frame_start,
  input  logic                chan,
  input  logic [SLOT_W-1:0]   slot,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                sdout
);
  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] pend_l_q, pend_r_q, act_l_q, act_r_q;
  logic [SAMPLE_W-1:0] pend_l_d, pend_r_d, act_l_d, act_r_d, word;
  logic                pend_full_q, pend_full_d, take, load, bit_on;
  logic [IDX_W-1:0]    idx;
  int                  n, off, k;

  always_comb begin
    take        = smp_valid && !pend_full_q;
    load        = pend_full_q && (frame_start || !run);
    pend_full_d = load ? 1'b0 : (take ? 1'b1 : pend_full_q);
    pend_l_d    = take ? smp_left  : pend_l_q;
    pend_r_d    = take ? smp_right : pend_r_q;
    act_l_d     = load ? pend_l_q  : act_l_q;
    act_r_d     = load ? pend_r_q  : act_r_q;
  end

  always_comb begin
    n = int'(res_bits(res));
    case (fmt)
      FMT_I2S: off = 1;
      FMT_RJ:  off = int'(half) - n;
      default: off = 0;
    endcase
    k      = int'(slot) - off;
    bit_on = (k >= 0) && (k < n);
    idx    = bit_on ? IDX_W'(SAMPLE_W - 1 - k) : '0;
    word   = chan ? act_r_q : act_l_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_full_q <= 1'b0;
      pend_l_q    <= '0;
      pend_r_q    <= '0;
      act_l_q     <= '0;
      act_r_q     <= '0;
    end else begin
      pend_full_q <= pend_full_d;
      pend_l_q    <= pend_l_d;
      pend_r_q    <= pend_r_d;
      act_l_q     <= act_l_d;
      act_r_q     <= act_r_d;
    end
  end

  assign smp_ready = !pend_full_q;
  assign sdout     = run && bit_on && word[idx];

  // R8
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
endmodule

// File: rtl/serial_audio_out.sv
module serial_audio_out
  import sao_pkg::*;
(
  input  logic                mclk,
  input  logic                rst_n,
  input  logic                pdn,
  input  logic                cfg_we,
  input  logic                cfg_master,
  input  logic                cfg_bclk_sel,
  input  logic [1:0]          cfg_res,
  input  logic [1:0]          cfg_fmt,
  input  logic [3:0]          cfg_ratio,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                sclk_in,
  input  logic                lrck_in,
  output logic                sclk_out,
  output logic                sclk_oe,
  output logic                lrck_out,
  output logic                lrck_oe,
  output logic                sdout,
  output logic                frame_err
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n, run, chan, frame_start;
  logic [SLOT_W-1:0] slot, half;
  cfg_t              wr_cfg, cfg_q;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign run    = !pdn;
  assign wr_cfg = '{master: cfg_master, bclk_sel: cfg_bclk_sel, res: cfg_res,
                    fmt: fmt_e'(cfg_fmt), ratio: cfg_ratio};
  assign half   = half_len(cfg_q.ratio, cfg_q.bclk_sel);

  sao_cfg i_cfg (
    .clk    (mclk),
    .rst_n  (rst_int_n),
    .pdn    (pdn),
    .wr_en  (cfg_we),
    .wr_cfg (wr_cfg),
    .cfg_q  (cfg_q)
  );

  sao_timing i_timing (
    .clk         (mclk),
    .rst_n       (rst_int_n),
    .run         (run),
    .cfg         (cfg_q),
    .sclk_in     (sclk_in),
    .lrck_in     (lrck_in),
    .chan        (chan),
    .slot        (slot),
    .frame_start (frame_start),
    .sclk_out    (sclk_out),
    .lrck_out    (lrck_out),
    .err_frame   (frame_err)
  );

  sao_shift i_shift (
    .clk         (mclk),
    .rst_n       (rst_int_n),
    .run         (run),
    .fmt         (cfg_q.fmt),
    .res         (cfg_q.res),
    .half        (half),
    .frame_start (frame_start),
    .chan        (chan),
    .slot        (slot),
    .smp_valid   (smp_valid),
    .smp_ready   (smp_ready),
    .smp_left    (smp_left),
    .smp_right   (smp_right),
    .sdout       (sdout)
  );

  assign sclk_oe = run && cfg_q.master;
  assign lrck_oe = run && cfg_q.master;
endmodule

// File: tb/test_serial_audio_out.sv
module test_serial_audio_out;
  logic clk = 1'b0;
  logic rst_n, pdn, cfg_we, cfg_master, cfg_bclk_sel;
  logic [1:0] cfg_res, cfg_fmt;
  logic [3:0] cfg_ratio;
  logic smp_valid, smp_ready, sclk_in, lrck_in;
  logic [23:0] smp_left, smp_right;
  logic sclk_out, sclk_oe, lrck_out, lrck_oe, sdout, frame_err;

  int checks = 0;
  int errors = 0;
  int err_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_audio_out i_serial_audio_out (
    .mclk(clk), .rst_n(rst_n), .pdn(pdn), .cfg_we(cfg_we), .cfg_master(cfg_master),
    .cfg_bclk_sel(cfg_bclk_sel), .cfg_res(cfg_res), .cfg_fmt(cfg_fmt), .cfg_ratio(cfg_ratio),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .sclk_in(sclk_in), .lrck_in(lrck_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .lrck_out(lrck_out), .lrck_oe(lrck_oe), .sdout(sdout), .frame_err(frame_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int res_n(input int r);
    return (r == 0) ? 24 : (r == 1) ? 20 : (r == 2) ? 18 : 16;
  endfunction

  function automatic int half_n(input int code, input int bsel);
    int b;
    b = (code == 5 || code == 7) ? 24 : 32;
    return bsel ? 2 * b : b;
  endfunction

  function automatic int div_n(input int code, input int bsel);
    int ratio;
    ratio = (code == 4) ? 256 : (code == 5) ? 384 : (code == 6) ? 512 : (code == 7) ? 768 : 1024;
    return ratio / (2 * half_n(code, bsel));
  endfunction

  function automatic bit exp_bit(input int fmt, input int res, input int half, input int s,
                                 input logic [23:0] w);
    int n, pos;
    n   = res_n(res);
    pos = (fmt == 0) ? s : (fmt == 1) ? s - 1 : s - (half - n);
    if (pos < 0 || pos >= n) return 1'b0;
    return w[23 - pos];
  endfunction

  task automatic tick();
    @(negedge clk);
    if (frame_err) err_seen++;
  endtask

  task automatic write_cfg(input bit m, input bit b, input int r, input int f, input int c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_master = m; cfg_bclk_sel = b;
    cfg_res = 2'(r); cfg_fmt = 2'(f); cfg_ratio = 4'(c);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    smp_valid = 1'b1; smp_left = l; smp_right = r;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic measure_period(output int p);
    int c;
    logic pv;
    pv = sclk_out;
    c = 0;
    while (!(sclk_out && !pv)) begin pv = sclk_out; @(negedge clk); end
    pv = sclk_out;
    @(negedge clk);
    c = 1;
    while (!(sclk_out && !pv)) begin pv = sclk_out; @(negedge clk); c++; end
    p = c;
  endtask

  task automatic run_master(input int fmt, input int res, input int code, input int bsel,
                            input logic [23:0] l0, input logic [23:0] r0, input int nframes,
                            input bit push_b, input logic [23:0] l1, input logic [23:0] r1);
    int h, total, rises, cyc, last, idx, s;
    bit ch, pushing;
    logic pv;
    logic [23:0] w;
    string tag;
    @(negedge clk);
    pdn = 1'b1;
    write_cfg(1'b1, 1'(bsel), res, fmt, code);
    push(l0, r0);
    repeat (2) @(negedge clk);
    // R10: idle while powered down
    chk(!sdout && !sclk_oe && !lrck_oe, "R10 idle", int'({sdout, sclk_oe, lrck_oe}), 0);
    pdn = 1'b0;
    h = half_n(code, bsel);
    total = 2 * h * nframes;
    rises = 0; cyc = 0; last = 0; pv = 1'b0; pushing = 1'b0;
    tag = (fmt == 0) ? "R1/R2" : (fmt == 1) ? "R1/R3" : "R1/R4";
    while (rises < total) begin
      @(negedge clk);
      cyc++;
      if (pushing) begin
        smp_valid = 1'b0;
        pushing = 1'b0;
        // R8: pending slot now full
        chk(!smp_ready, "R8 ready low", int'(smp_ready), 0);
      end
      if (sclk_out && !pv) begin
        idx = rises % (2 * h);
        ch  = (idx >= h);
        s   = idx % h;
        if (push_b && rises >= 2 * h) w = ch ? r1 : l1;
        else                          w = ch ? r0 : l0;
        chk(sdout == exp_bit(fmt, res, h, s, w), tag, int'(sdout), int'(exp_bit(fmt, res, h, s, w)));
        // R5: frame clock level, left polarity by format
        chk(lrck_out == ((fmt == 1) ? ch : !ch), "R5 lrck", int'(lrck_out), int'((fmt == 1) ? ch : !ch));
        if (rises == 0) chk(sclk_oe && lrck_oe, "R5 oe", int'({sclk_oe, lrck_oe}), 3);
        if (rises == 1) chk(cyc - last == div_n(code, bsel), "R5 period", cyc - last, div_n(code, bsel));
        if (rises == 2 && push_b) begin
          smp_valid = 1'b1; smp_left = l1; smp_right = r1; pushing = 1'b1;
        end
        last = cyc;
        rises++;
      end
      pv = sclk_out;
    end
  endtask

  task automatic slave_half(input bit lvl, input int nslots, input bit check, input int fmt,
                            input int res, input logic [23:0] w);
    for (int s = 0; s < nslots; s++) begin
      @(negedge clk);
      sclk_in = 1'b0;
      if (s == 0) lrck_in = lvl;
      repeat (4) tick();
      if (check)
        chk(sdout == exp_bit(fmt, res, 32, s, w), "R6 slave data", int'(sdout),
            int'(exp_bit(fmt, res, 32, s, w)));
      sclk_in = 1'b1;
      repeat (3) tick();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p, idx;
    logic [23:0] a, b, la, lb;
    rst_n = 1'b0; pdn = 1'b1; cfg_we = 1'b0; cfg_master = 1'b0; cfg_bclk_sel = 1'b0;
    cfg_res = '0; cfg_fmt = '0; cfg_ratio = 4'd4; smp_valid = 1'b0;
    smp_left = '0; smp_right = '0; sclk_in = 1'b1; lrck_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 / R10: reset state
    chk(smp_ready, "R8 reset ready", int'(smp_ready), 1);
    chk(!sclk_oe && !lrck_oe && !sdout && !frame_err, "R10 reset outputs",
        int'({sclk_oe, lrck_oe, sdout, frame_err}), 0);

    // master sweep over every format, resolution, ratio and bit-clock choice
    idx = 0;
    for (int f = 0; f < 3; f++)
      for (int r = 0; r < 4; r++)
        for (int c = 4; c <= 8; c++)
          for (int bs = 0; bs < 2; bs++) begin
            a = 24'h9A5C3E ^ 24'(idx * 24'h0F1E1);
            b = {a[11:0], ~a[23:12]};
            run_master(f, r, c, bs, a, b, 1, 1'b0, '0, '0);
            idx++;
          end

    // R8: mid-frame push used next frame, then repeated
    la = 24'hC0FFEE; lb = 24'h123456;
    run_master(0, 0, 4, 0, la, ~la, 3, 1'b1, lb, ~lb);
    // R8: no push, previous pair repeats
    run_master(1, 2, 6, 1, 24'hA1B2C3, 24'h5D6E7F, 2, 1'b0, '0, '0);

    // R7: write while running is ignored
    write_cfg(1'b1, 1'b0, 0, 0, 8);
    measure_period(p);
    chk(p == 4, "R7 write while running", p, 4);
    @(negedge clk) pdn = 1'b1;
    // R7: illegal ratio code and reserved format are discarded
    write_cfg(1'b1, 1'b0, 0, 0, 3);
    write_cfg(1'b1, 1'b0, 0, 3, 8);
    @(negedge clk) pdn = 1'b0;
    measure_period(p);
    chk(p == 4, "R7 illegal codes", p, 4);

    // slave, left-justified; right-justified in slave mode must be rejected (R4)
    @(negedge clk) pdn = 1'b1;
    sclk_in = 1'b1; lrck_in = 1'b0;
    write_cfg(1'b0, 1'b0, 0, 0, 4);
    write_cfg(1'b0, 1'b0, 0, 2, 4);
    a = 24'hB4D2E1; b = 24'h3C5A69;
    push(a, b);
    repeat (3) @(negedge clk);
    pdn = 1'b0;
    repeat (4) @(negedge clk);
    chk(!sclk_oe && !lrck_oe, "R6 slave oe", int'({sclk_oe, lrck_oe}), 0);
    slave_half(1'b0, 4, 1'b0, 0, 0, '0);
    err_seen = 0;
    for (int fr = 0; fr < 2; fr++) begin
      slave_half(1'b1, 32, 1'b1, 0, 0, a);
      slave_half(1'b0, 32, 1'b1, 0, 0, b);
    end
    // R4 rejection shows as left-justified data above; R9 no false flag
    chk(err_seen == 0, "R9 good frames", err_seen, 0);
    slave_half(1'b1, 30, 1'b0, 0, 0, '0);
    slave_half(1'b0, 32, 1'b0, 0, 0, '0);
    slave_half(1'b1, 2, 1'b0, 0, 0, '0);
    chk(err_seen == 1, "R9 short half flagged", err_seen, 1);

    // slave I2S, 20-bit: left while frame clock low (R3)
    @(negedge clk) pdn = 1'b1;
    sclk_in = 1'b1; lrck_in = 1'b1;
    write_cfg(1'b0, 1'b0, 1, 1, 4);
    a = 24'h6F0A93; b = 24'hE71C45;
    push(a, b);
    repeat (3) @(negedge clk);
    pdn = 1'b0;
    repeat (4) @(negedge clk);
    slave_half(1'b1, 4, 1'b0, 1, 1, '0);
    err_seen = 0;
    slave_half(1'b0, 32, 1'b1, 1, 1, a);
    slave_half(1'b1, 32, 1'b1, 1, 1, b);
    slave_half(1'b0, 2, 1'b0, 1, 1, '0);
    chk(err_seen == 0, "R3/R9 i2s slave frame", err_seen, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule